// File: doc/BRIEF.md
# Block-Erase Hold Timer and Sequencer

This block is the erase front end of a flash-style memory controller. An upstream decoder hands it one-cycle command pulses. Each pulse carries an opcode and a block index. A block-erase command marks its block in a pending bitmap, drops the ready flag and opens a hold window. Every further block-erase command that arrives while the window is open marks one more block and restarts the window. Several blocks can therefore be batched into a single erase.

When the window runs out with no new command, the erase phase starts and the timer status flag goes high. A cycle counter stands in for the erase. It runs for a fixed number of cycles for each marked block. While the erase runs, the only command that has any effect is suspend, and it freezes the counter until a resume arrives. An injected fail input ends the erase early and leaves the flags in a failure pattern. The next block-erase command clears that pattern.

Top module: `erase_hold_seq`

## Requirements
- R1: After a synchronous active-low reset, ready is 1, the timer flag is 0, suspended is 0 and the pending bitmap is 0. No erase starts until a block-erase command arrives.
- R2: A block-erase command (opcode 2'b01) sampled while ready is 1 and suspended is 0 gives ready 0 and timer flag 0 from the next cycle on, and sets bit `cmd_blk` of the bitmap.
- R3: The erase starts (timer flag rises) exactly HOLD_CYCLES clock edges after the edge that sampled the last block-erase command, provided no further block-erase command is sampled in between.
- R4: A block-erase command sampled during the hold window, including on its final cycle, restarts the full HOLD_CYCLES countdown and adds its block to the bitmap. A repeated index leaves the bitmap unchanged.
- R5: The timer flag is 0 throughout the hold window and 1 while the erase runs or is suspended.
- R6: An erase with k marked blocks keeps ready at 0 for k*CYCLES_PER_BLOCK cycles after it starts. Ready then returns to 1, the timer flag to 0 and the bitmap to 0.
- R7: While the erase runs, block-erase (2'b01), other (2'b00) and resume (2'b11) commands are ignored. The bitmap and the completion cycle do not change.
- R8: A suspend command (2'b10) sampled during the erase sets suspended 1, ready 1 and timer flag 1, and freezes the erase counter. In this state every command except resume is ignored. After resume (2'b11), ready stays 0 for the remaining k*CYCLES_PER_BLOCK - m cycles, where m is the number of counting cycles completed before the suspend. Suspend during the hold window is ignored.
- R9: `fail_inj` high during a running erase ends it at once with ready 1, timer flag 1 and the bitmap cleared. A following block-erase command starts a new hold window normally.
- R10: While idle, other, suspend and resume commands and `fail_inj` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | Opcode: 00 other, 01 block erase, 10 suspend, 11 resume |
| cmd_blk | input | $clog2(NUM_BLOCKS) | Block index for block erase |
| fail_inj | input | 1 | Injected erase failure |
| ready_o | output | 1 | 1 = ready, 0 = busy |
| timer_o | output | 1 | 0 during the hold window, 1 once the erase has started or failed |
| suspended_o | output | 1 | Erase is suspended |
| pending_map | output | NUM_BLOCKS | Blocks marked for the current erase |

## Verification
Some properties are checked on every cycle. A block-erase command accepted from an idle, failed or holding state always gives a busy, timer-low state next. The bitmap never changes while the erase runs, except to clear. The bitmap is empty whenever the block is idle. The timer flag never rises in the cycle right after a block-erase command. A suspended erase stays suspended with a frozen bitmap until resume. A failure always lands in the ready, timer-high, empty-bitmap state. Other behaviour only the bench scenarios can show: the exact number of hold cycles, window restart on the final hold cycle, erase lengths for different batch sizes, and the remaining length after a suspend and resume.

// File: rtl/ehs_pkg.sv
// Shared types for the block-erase hold sequencer.
// Assumes a 2-bit opcode field supplied by an upstream command decoder.
package ehs_pkg;

    typedef enum logic [1:0] {
        OP_OTHER   = 2'b00,
        OP_ERASE   = 2'b01,
        OP_SUSPEND = 2'b10,
        OP_RESUME  = 2'b11
    } ehs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_ERASE = 3'd2,
        ST_SUSP  = 3'd3,
        ST_FAIL  = 3'd4
    } ehs_state_e;

endpackage

// File: rtl/ehs_hold_timer.sv
// Hold-window countdown. A load sets the count to HOLD_CYCLES. While run is
// high the count falls to 1, and expire pulses in the cycle the count sits at 1
// with no load. Assumes HOLD_CYCLES >= 1.
module ehs_hold_timer #(
    parameter int HOLD_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int W = $clog2(HOLD_CYCLES + 1);

    logic [W-1:0] cnt_q;

    assign expire = run && !load && (cnt_q == W'(1));

    // Reload on command, count down while the window is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= W'(HOLD_CYCLES);
        end else if (run && (cnt_q > W'(1))) begin
            cnt_q <= cnt_q - W'(1);
        end
    end
endmodule

// File: rtl/ehs_block_map.sv
// Pending-block bitmap, one flop per block, with a population count.
// An index at or above NUM_BLOCKS sets nothing. Clear wins over set.
module ehs_block_map #(
    parameter int NUM_BLOCKS = 8,
    parameter int IDX_W      = 3,
    parameter int CNT_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [IDX_W-1:0]      set_idx,
    input  logic                  clr,
    output logic [NUM_BLOCKS-1:0] map,
    output logic [CNT_W-1:0]      count
);
    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_bit
        logic mark_q;
        // Hold one block's pending mark.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mark_q <= 1'b0;
            end else if (clr) begin
                mark_q <= 1'b0;
            end else if (set_en && (set_idx == IDX_W'(i))) begin
                mark_q <= 1'b1;
            end
        end
        assign map[i] = mark_q;
    end

    // Count the marked blocks.
    always_comb begin
        count = '0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            count = count + CNT_W'(map[i]);
        end
    end
endmodule

// File: rtl/ehs_erase_ctr.sv
// Erase progress counter. Clear zeroes it and run advances it. last is high
// while the count equals limit-1. Assumes limit >= 1 whenever last is used.
module ehs_erase_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_q;

    assign last = (cnt_q == (limit - W'(1)));

    // Track completed erase cycles; frozen whenever run is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/ehs_ctrl.sv
// Sequencer state machine: idle -> hold -> erase -> idle, with suspend and
// fail branches. Flags come straight from the state register. Assumes
// commands are one-cycle pulses.
module ehs_ctrl
    import ehs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       fail_inj,
    input  logic       expire,
    input  logic       last,
    output logic       timer_load,
    output logic       timer_run,
    output logic       map_set,
    output logic       map_clr,
    output logic       ctr_clr,
    output logic       ctr_run,
    output logic       ready_o,
    output logic       timer_o,
    output logic       suspended_o
);
    ehs_state_e state_q, state_d;
    logic is_erase, is_susp, is_resume;

    assign is_erase  = cmd_valid && (cmd_op == OP_ERASE);
    assign is_susp   = cmd_valid && (cmd_op == OP_SUSPEND);
    assign is_resume = cmd_valid && (cmd_op == OP_RESUME);

    // Next-state and control-strobe decode.
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_run  = 1'b0;
        map_set    = 1'b0;
        map_clr    = 1'b0;
        ctr_clr    = 1'b0;
        ctr_run    = 1'b0;
        case (state_q)
            ST_IDLE, ST_FAIL: begin
                if (is_erase) begin
                    state_d    = ST_HOLD;
                    timer_load = 1'b1;
                    map_set    = 1'b1;
                end
            end
            ST_HOLD: begin
                timer_run = 1'b1;
                if (is_erase) begin
                    timer_load = 1'b1;
                    map_set    = 1'b1;
                end else if (expire) begin
                    state_d = ST_ERASE;
                    ctr_clr = 1'b1;
                end
            end
            ST_ERASE: begin
                if (fail_inj) begin
                    state_d = ST_FAIL;
                    map_clr = 1'b1;
                end else if (last) begin
                    state_d = ST_IDLE;
                    map_clr = 1'b1;
                end else if (is_susp) begin
                    state_d = ST_SUSP;
                end else begin
                    ctr_run = 1'b1;
                end
            end
            ST_SUSP: begin
                if (is_resume) begin
                    state_d = ST_ERASE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign ready_o     = (state_q == ST_IDLE) || (state_q == ST_SUSP) || (state_q == ST_FAIL);
    assign timer_o     = (state_q == ST_ERASE) || (state_q == ST_SUSP) || (state_q == ST_FAIL);
    assign suspended_o = (state_q == ST_SUSP);
endmodule

// File: rtl/erase_hold_seq.sv
// Top of the block-erase hold sequencer. Batches block-erase commands inside
// a restartable hold window, then runs a modelled erase of
// CYCLES_PER_BLOCK cycles for each marked block.
// Assumes NUM_BLOCKS >= 2, HOLD_CYCLES >= 1, CYCLES_PER_BLOCK >= 1.
module erase_hold_seq #(
    parameter int NUM_BLOCKS       = 8,
    parameter int HOLD_CYCLES      = 5000,
    parameter int CYCLES_PER_BLOCK = 64,
    localparam int IDX_W           = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [IDX_W-1:0]      cmd_blk,
    input  logic                  fail_inj,
    output logic                  ready_o,
    output logic                  timer_o,
    output logic                  suspended_o,
    output logic [NUM_BLOCKS-1:0] pending_map
);
    localparam int CNT_W = $clog2(NUM_BLOCKS + 1);
    localparam int TOT_W = $clog2(NUM_BLOCKS * CYCLES_PER_BLOCK + 1);

    logic timer_load, timer_run, expire;
    logic map_set, map_clr, ctr_clr, ctr_run, last;
    logic [CNT_W-1:0] blk_count;
    logic [TOT_W-1:0] erase_len;

    assign erase_len = TOT_W'(blk_count) * TOT_W'(CYCLES_PER_BLOCK);

    ehs_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .fail_inj    (fail_inj),
        .expire      (expire),
        .last        (last),
        .timer_load  (timer_load),
        .timer_run   (timer_run),
        .map_set     (map_set),
        .map_clr     (map_clr),
        .ctr_clr     (ctr_clr),
        .ctr_run     (ctr_run),
        .ready_o     (ready_o),
        .timer_o     (timer_o),
        .suspended_o (suspended_o)
    );

    ehs_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (timer_load),
        .run    (timer_run),
        .expire (expire)
    );

    ehs_block_map #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (map_set),
        .set_idx (cmd_blk),
        .clr     (map_clr),
        .map     (pending_map),
        .count   (blk_count)
    );

    ehs_erase_ctr #(.W(TOT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .run   (ctr_run),
        .limit (erase_len),
        .last  (last)
    );
endmodule

// File: rtl/ehs_checker.sv
// Cycle-level properties of the sequencer, observed at the top-level ports.
// Bound into every instance of erase_hold_seq.
module ehs_checker #(
    parameter int NUM_BLOCKS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid,
    input logic [1:0]            cmd_op,
    input logic                  fail_inj,
    input logic                  ready_o,
    input logic                  timer_o,
    input logic                  suspended_o,
    input logic [NUM_BLOCKS-1:0] pending_map
);
    logic erase_cmd, resume_cmd;
    assign erase_cmd  = cmd_valid && (cmd_op == 2'b01);
    assign resume_cmd = cmd_valid && (cmd_op == 2'b11);

    AST_ERASE_CMD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_cmd && !suspended_o && (ready_o || !timer_o)) |=> (!ready_o && !timer_o)); // R2

    AST_NO_START_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(timer_o) && !ready_o) |-> $past(!erase_cmd)); // R3

    AST_IDLE_EMPTY_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !timer_o) |-> (pending_map == '0)); // R6

    AST_ERASE_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && timer_o) |=> ($stable(pending_map) || (pending_map == '0))); // R7

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended_o && !resume_cmd) |=> (suspended_o && $stable(pending_map))); // R8

    AST_FAIL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && timer_o && fail_inj) |=> (ready_o && timer_o && (pending_map == '0))); // R9
endmodule

bind erase_hold_seq ehs_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .fail_inj    (fail_inj),
    .ready_o     (ready_o),
    .timer_o     (timer_o),
    .suspended_o (suspended_o),
    .pending_map (pending_map)
);

// File: tb/erase_hold_seq_tb.sv
// Self-checking bench: a vector table of erase batches, then directed tests.
module erase_hold_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 8;
    localparam int HOLD = 6;
    localparam int PB   = 3;
    localparam int IW   = 3;

    localparam logic [1:0] OPC_OTHER  = 2'b00;
    localparam logic [1:0] OPC_ERASE  = 2'b01;
    localparam logic [1:0] OPC_SUSP   = 2'b10;
    localparam logic [1:0] OPC_RESUME = 2'b11;

    typedef struct packed {
        logic [2:0] b0;
        logic [2:0] b1;
        logic [2:0] b2;
        logic [1:0] ncmd;
        logic [3:0] gap;
        logic [7:0] exp_map;
        logic [7:0] exp_len;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{3'd2, 3'd0, 3'd0, 2'd1, 4'd0, 8'h04, 8'd3},
        '{3'd0, 3'd5, 3'd7, 2'd3, 4'd2, 8'hA1, 8'd9},
        '{3'd3, 3'd3, 3'd6, 2'd3, 4'd5, 8'h48, 8'd6},
        '{3'd1, 3'd4, 3'd0, 2'd2, 4'd0, 8'h12, 8'd6}
    };

    logic clk = 1'b0;
    logic rst_n, cmd_valid, fail_inj;
    logic [1:0] cmd_op;
    logic [IW-1:0] cmd_blk;
    logic ready_o, timer_o, suspended_o;
    logic [NB-1:0] pending_map;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    erase_hold_seq #(.NUM_BLOCKS(NB), .HOLD_CYCLES(HOLD), .CYCLES_PER_BLOCK(PB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .fail_inj(fail_inj), .ready_o(ready_o),
        .timer_o(timer_o), .suspended_o(suspended_o), .pending_map(pending_map)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one command for one cycle; called and returns at a falling edge.
    task automatic send(input logic [1:0] op, input logic [IW-1:0] blk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_blk   = blk;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = OPC_OTHER;
        cmd_blk   = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = OPC_OTHER; cmd_blk = '0; fail_inj = 1'b0;
        idle(3);
        rst_n = 1'b1;
        chk("R1 ready", 32'(ready_o), 1);
        chk("R1 timer", 32'(timer_o), 0);
        chk("R1 susp", 32'(suspended_o), 0);
        chk("R1 map", 32'(pending_map), 0);

        // Vector table: batches of erase commands.
        for (int i = 0; i < 4; i++) begin
            send(OPC_ERASE, VEC[i].b0);
            chk("R2 ready", 32'(ready_o), 0);
            chk("R2 timer", 32'(timer_o), 0);
            if (VEC[i].ncmd >= 2) begin
                idle(int'(VEC[i].gap));
                send(OPC_ERASE, VEC[i].b1);
                chk("R4 still holding", 32'(timer_o), 0);
            end
            if (VEC[i].ncmd == 3) begin
                idle(int'(VEC[i].gap));
                send(OPC_ERASE, VEC[i].b2);
            end
            idle(HOLD - 1);
            chk("R3 hold not expired", 32'(timer_o), 0);
            idle(1);
            chk("R5 timer in erase", 32'(timer_o), 1);
            chk("R4 batched map", 32'(pending_map), 32'(VEC[i].exp_map));
            idle(int'(VEC[i].exp_len) - 1);
            chk("R6 busy before end", 32'(ready_o), 0);
            idle(1);
            chk("R6 ready at end", 32'(ready_o), 1);
            chk("R6 timer at end", 32'(timer_o), 0);
            chk("R6 map cleared", 32'(pending_map), 0);
        end

        // R7: commands ignored during the erase.
        send(OPC_ERASE, 3'd1);
        send(OPC_ERASE, 3'd2);
        idle(HOLD);
        chk("R7 erase started", 32'(timer_o), 1);
        send(OPC_ERASE, 3'd5);
        send(OPC_OTHER, 3'd6);
        send(OPC_RESUME, 3'd0);
        chk("R7 map unchanged", 32'(pending_map), 32'h06);
        idle(2);
        chk("R7 still busy", 32'(ready_o), 0);
        idle(1);
        chk("R7 completion unchanged", 32'(ready_o), 1);

        // R8: suspend ignored in hold, then suspend/resume during erase.
        send(OPC_ERASE, 3'd0);
        send(OPC_ERASE, 3'd1);
        send(OPC_SUSP, 3'd0);
        chk("R8 hold suspend ignored", 32'(suspended_o), 0);
        chk("R8 hold still busy", 32'(ready_o), 0);
        idle(HOLD - 2);
        chk("R8 hold timing", 32'(timer_o), 0);
        idle(1);
        chk("R8 erase started", 32'(timer_o), 1);
        idle(2);
        send(OPC_SUSP, 3'd0);
        chk("R8 suspended", 32'(suspended_o), 1);
        chk("R8 ready in suspend", 32'(ready_o), 1);
        chk("R8 timer in suspend", 32'(timer_o), 1);
        send(OPC_ERASE, 3'd7);
        idle(8);
        chk("R8 map frozen", 32'(pending_map), 32'h03);
        chk("R8 still suspended", 32'(suspended_o), 1);
        send(OPC_RESUME, 3'd0);
        chk("R8 resumed", 32'(suspended_o), 0);
        chk("R8 busy after resume", 32'(ready_o), 0);
        idle(3);
        chk("R8 remaining busy", 32'(ready_o), 0);
        idle(1);
        chk("R8 done after remainder", 32'(ready_o), 1);
        chk("R8 map cleared", 32'(pending_map), 0);

        // R9: injected failure.
        send(OPC_ERASE, 3'd7);
        idle(HOLD + 1);
        fail_inj = 1'b1;
        @(negedge clk);
        fail_inj = 1'b0;
        chk("R9 ready", 32'(ready_o), 1);
        chk("R9 timer", 32'(timer_o), 1);
        chk("R9 map", 32'(pending_map), 0);
        send(OPC_ERASE, 3'd2);
        chk("R9 new hold ready", 32'(ready_o), 0);
        chk("R9 new hold timer", 32'(timer_o), 0);
        chk("R9 new hold map", 32'(pending_map), 32'h04);
        idle(HOLD + PB);
        chk("R9 new erase done", 32'(ready_o), 1);
        chk("R9 new erase timer", 32'(timer_o), 0);

        // R10: non-erase inputs in idle.
        send(OPC_OTHER, 3'd3);
        send(OPC_SUSP, 3'd3);
        send(OPC_RESUME, 3'd3);
        fail_inj = 1'b1;
        @(negedge clk);
        fail_inj = 1'b0;
        chk("R10 ready", 32'(ready_o), 1);
        chk("R10 timer", 32'(timer_o), 0);
        chk("R10 susp", 32'(suspended_o), 0);
        chk("R10 map", 32'(pending_map), 0);

        // R1: reset during the hold window.
        send(OPC_ERASE, 3'd5);
        idle(2);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid reset ready", 32'(ready_o), 1);
        chk("R1 mid reset map", 32'(pending_map), 0);
        idle(HOLD + 2);
        chk("R1 no erase after reset", 32'(timer_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule